// File: doc/BRIEF.md
# XGMII Link Fault Sequencer

This block sits in the reconciliation layer between a 10G MAC and a 32-bit XGMII made of four lanes, each lane one data byte plus one control bit, with control bit i qualifying data byte i. It watches every receive column for sequence-ordered-set fault messages. It declares a fault only when four messages of the same kind arrive within a 128-column window, and it drops the fault once 128 columns in a row carry no fault message.

While a fault is active, the transmit XGMII answers the link partner instead of carrying MAC traffic. A local fault is answered with continuous remote fault columns. A remote fault is answered with idle columns. When the link is OK, the MAC's transmit columns pass through with one register of delay.

Both XGMII directions are continuous streams: one column is accepted and one column is produced on every clock. There is no valid or ready, and no back-pressure exists in either direction. The link status is a plain output.

Top module: `xgmii_fault_sequencer`

## Requirements
- R1: While reset is asserted and on the first cycle after it, link_status is 0 (OK) and the transmit column is idle: every data byte is 0x07 and all four control bits are 1.
- R2: While link_status is OK, the transmit column equals the MAC column of the previous clock, for both data and control.
- R3: A fault message has control 4'b0001, lane 0 equal to 0x9C, lanes 1 and 2 equal to 0x00, and lane 3 equal to 0x01 for local or 0x02 for remote. The fourth local message of a counting run sets link_status to 1 (Local Fault) on the clock that samples it, and no earlier message does so.
- R4: A counting run starts at its first message, which is offset 0. A message at column offset 127 still counts. A message at offset 128 or later starts a new run instead.
- R5: From the clock after link_status becomes Local Fault, and for as long as it stays there, every transmit column is a remote fault column: data 0x0200009C with control 4'b0001. The MAC input is ignored during this time.
- R6: A fault status returns to OK on the 128th consecutive received column that is not a fault message. Any fault message restarts this run of quiet columns.
- R7: Four remote messages in one run set link_status to 2 (Remote Fault). From the next clock on, the transmit output is the idle column.
- R8: A fault message of the other type from the one being counted restarts the run, so that it counts as message one of a new run.
- R9: Received columns that are not fault messages, such as data, idle or terminate columns, do not reset the count while the window is open.
- R10: A column that differs from a fault message in any control bit or any lane byte is not a fault message.
- R11: A completed run of the other fault type replaces the current fault status directly, without passing through OK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | XGMII column clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_data | input | 32 | Receive column data, lane 0 in bits 7:0 |
| rx_ctrl | input | 4 | Receive column control, bit i qualifies lane i |
| mac_txd | input | 32 | Transmit column data from the MAC |
| mac_txc | input | 4 | Transmit column control from the MAC |
| xgmii_txd | output | 32 | Transmit column data to the PHY |
| xgmii_txc | output | 4 | Transmit column control to the PHY |
| link_status | output | 2 | 0 OK, 1 Local Fault, 2 Remote Fault |

## Verification
Local messages are sent with gaps that place the fourth one at column offset 120, at 127 and at 128 or more. This separates a correct window edge from an off-by-one in either direction. Mixed sequences with a type change after three messages show that the run restarts. Data, idle, terminate and near-miss columns between messages show that only exact matches count and that ordinary traffic does not reset the run. Quiet runs of 127 and 128 columns after a fault pin the clearing edge. A remote run that completes while a local fault is held shows that the status changes directly from one fault to the other.

// File: rtl/lfs_pkg.sv
package lfs_pkg;

  typedef enum logic [1:0] {
    ST_OK     = 2'd0,
    ST_LOCAL  = 2'd1,
    ST_REMOTE = 2'd2
  } link_st_e;

  typedef enum logic [1:0] {
    MSG_NONE   = 2'd0,
    MSG_LOCAL  = 2'd1,
    MSG_REMOTE = 2'd2
  } msg_e;

  localparam logic [7:0]  SEQ_CHAR   = 8'h9C;
  localparam logic [7:0]  LF_CODE    = 8'h01;
  localparam logic [7:0]  RF_CODE    = 8'h02;
  localparam logic [3:0]  SEQ_CTRL   = 4'b0001;
  localparam logic [31:0] COL_RF     = {RF_CODE, 16'h0000, SEQ_CHAR};
  localparam logic [31:0] COL_IDLE   = 32'h07070707;
  localparam logic [3:0]  CTRL_IDLE  = 4'b1111;

endpackage

// File: rtl/lfs_msg_decode.sv
module lfs_msg_decode
  import lfs_pkg::*;
(
  input  logic [31:0] col_data,
  input  logic [3:0]  col_ctrl,
  output msg_e        msg
);

  logic is_seq;

  always_comb begin
    is_seq = (col_ctrl == SEQ_CTRL) && (col_data[7:0] == SEQ_CHAR) &&
             (col_data[23:8] == 16'h0000);
    msg = MSG_NONE;
    if (is_seq) begin
      if (col_data[31:24] == LF_CODE)      msg = MSG_LOCAL;
      else if (col_data[31:24] == RF_CODE) msg = MSG_REMOTE;
    end
  end

endmodule

// File: rtl/lfs_fault_counter.sv
module lfs_fault_counter
  import lfs_pkg::*;
#(
  parameter int WINDOW = 128,
  parameter int COUNT  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  msg_e msg,
  output logic hit,
  output msg_e hit_type
);

  localparam int WW = $clog2(WINDOW + 1);
  localparam int CW = $clog2(COUNT + 1);
  localparam logic [WW-1:0] WIN_LIM  = WW'(WINDOW);
  localparam logic [CW-1:0] CNT_LAST = CW'(COUNT - 1);

  logic [WW-1:0] win_q, win_n;
  logic [CW-1:0] cnt_q, cnt_n;
  msg_e          typ_q, typ_n;
  logic          live;

  always_comb begin
    live     = (cnt_q != '0) && (win_q < WIN_LIM);
    cnt_n    = cnt_q;
    win_n    = win_q;
    typ_n    = typ_q;
    hit      = 1'b0;
    hit_type = msg;
    if (msg != MSG_NONE) begin
      if (live && msg == typ_q) begin
        if (cnt_q == CNT_LAST) begin
          hit   = 1'b1;
          cnt_n = '0;
          win_n = '0;
        end else begin
          cnt_n = cnt_q + 1'b1;
          win_n = win_q + 1'b1;
        end
      end else begin
        cnt_n = CW'(1);
        win_n = WW'(1);
        typ_n = msg;
      end
    end else if (live) begin
      win_n = win_q + 1'b1;
    end else begin
      cnt_n = '0;
      win_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      win_q <= '0;
      typ_q <= MSG_NONE;
    end else begin
      cnt_q <= cnt_n;
      win_q <= win_n;
      typ_q <= typ_n;
    end
  end

  // R8: a message of the other kind starts a fresh run at count one
  a_r8_type_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (msg != MSG_NONE && cnt_q != '0 && msg != typ_q) |=> (cnt_q == CW'(1)));

  // R4: the column offset never runs past the window limit
  a_r4_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
    win_q <= WIN_LIM);

endmodule

// File: rtl/lfs_link_state.sv
module lfs_link_state
  import lfs_pkg::*;
#(
  parameter int CLEAR = 128
) (
  input  logic     clk,
  input  logic     rst_n,
  input  msg_e     msg,
  input  logic     hit,
  input  msg_e     hit_type,
  output link_st_e status
);

  localparam int RW = $clog2(CLEAR + 1);
  localparam logic [RW-1:0] RUN_LIM = RW'(CLEAR);

  logic [RW-1:0] run_q, run_n;
  link_st_e      st_n;

  always_comb begin
    if (msg != MSG_NONE)     run_n = '0;
    else if (run_q == RUN_LIM) run_n = run_q;
    else                     run_n = run_q + 1'b1;
    st_n = status;
    if (hit)                    st_n = (hit_type == MSG_LOCAL) ? ST_LOCAL : ST_REMOTE;
    else if (run_n == RUN_LIM)  st_n = ST_OK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      status <= ST_OK;
    end else begin
      run_q  <= run_n;
      status <= st_n;
    end
  end

  // R6: a fault message never clears an active fault
  a_r6_msg_holds_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (status != ST_OK && msg != MSG_NONE) |=> (status != ST_OK));

  // R3: a completed run always leaves a fault status behind
  a_r3_hit_sets_fault: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (status != ST_OK));

endmodule

// File: rtl/lfs_tx_override.sv
module lfs_tx_override
  import lfs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  link_st_e    status,
  input  logic [31:0] mac_txd,
  input  logic [3:0]  mac_txc,
  output logic [31:0] txd,
  output logic [3:0]  txc
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txd <= COL_IDLE;
      txc <= CTRL_IDLE;
    end else begin
      unique case (status)
        ST_OK: begin
          txd <= mac_txd;
          txc <= mac_txc;
        end
        ST_LOCAL: begin
          txd <= COL_RF;
          txc <= SEQ_CTRL;
        end
        default: begin
          txd <= COL_IDLE;
          txc <= CTRL_IDLE;
        end
      endcase
    end
  end

  // R2: pass-through of the MAC column while the link is OK
  a_r2_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
    (status == ST_OK) |=> (txd == $past(mac_txd) && txc == $past(mac_txc)));

  // R5: local fault is answered with remote fault columns
  a_r5_answer_local: assert property (@(posedge clk) disable iff (!rst_n)
    (status == ST_LOCAL) |=> (txd == COL_RF && txc == SEQ_CTRL));

  // R7: remote fault is answered with idle columns
  a_r7_answer_remote: assert property (@(posedge clk) disable iff (!rst_n)
    (status == ST_REMOTE) |=> (txd == COL_IDLE && txc == CTRL_IDLE));

endmodule

// File: rtl/xgmii_fault_sequencer.sv
module xgmii_fault_sequencer
  import lfs_pkg::*;
#(
  parameter int WINDOW = 128,
  parameter int COUNT  = 4,
  parameter int CLEAR  = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] rx_data,
  input  logic [3:0]  rx_ctrl,
  input  logic [31:0] mac_txd,
  input  logic [3:0]  mac_txc,
  output logic [31:0] xgmii_txd,
  output logic [3:0]  xgmii_txc,
  output logic [1:0]  link_status
);

  msg_e     rx_msg;
  logic     run_hit;
  msg_e     run_type;
  link_st_e st;

  lfs_msg_decode u_decode (
    .col_data (rx_data),
    .col_ctrl (rx_ctrl),
    .msg      (rx_msg)
  );

  lfs_fault_counter #(.WINDOW(WINDOW), .COUNT(COUNT)) u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .msg      (rx_msg),
    .hit      (run_hit),
    .hit_type (run_type)
  );

  lfs_link_state #(.CLEAR(CLEAR)) u_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .msg      (rx_msg),
    .hit      (run_hit),
    .hit_type (run_type),
    .status   (st)
  );

  lfs_tx_override u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .status  (st),
    .mac_txd (mac_txd),
    .mac_txc (mac_txc),
    .txd     (xgmii_txd),
    .txc     (xgmii_txc)
  );

  assign link_status = st;

endmodule

// File: tb/xgmii_fault_sequencer_test.sv
module xgmii_fault_sequencer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] rx_data = 32'h07070707;
  logic [3:0]  rx_ctrl = 4'hF;
  logic [31:0] mac_txd = 32'h0;
  logic [3:0]  mac_txc = 4'h0;
  logic [31:0] xgmii_txd;
  logic [3:0]  xgmii_txc;
  logic [1:0]  link_status;

  int checks = 0;
  int fails = 0;
  bit cmp_en = 0;
  bit done = 0;
  logic [31:0] last_mac_d = 32'h0;
  logic [3:0]  last_mac_c = 4'h0;

  localparam logic [31:0] LF = 32'h0100009C;
  localparam logic [31:0] RF = 32'h0200009C;
  localparam logic [31:0] IDL = 32'h07070707;

  always #10 clk = ~clk;

  xgmii_fault_sequencer uut (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_ctrl(rx_ctrl),
    .mac_txd(mac_txd), .mac_txc(mac_txc), .xgmii_txd(xgmii_txd),
    .xgmii_txc(xgmii_txc), .link_status(link_status)
  );

  // behavioural reference
  int m_cnt = 0, m_type = 0, m_first = 0, m_cyc = 0, m_run = 0;
  logic [1:0]  m_st = 2'd0;
  logic [31:0] e_txd = IDL;
  logic [3:0]  e_txc = 4'hF;

  function automatic int kind_of(logic [31:0] d, logic [3:0] c);
    if (c == 4'b0001 && d[7:0] == 8'h9C && d[15:8] == 8'h00 && d[23:16] == 8'h00) begin
      if (d[31:24] == 8'h01) return 1;
      if (d[31:24] == 8'h02) return 2;
    end
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_type = 0; m_first = 0; m_cyc = 0; m_run = 0;
      m_st = 2'd0; e_txd = IDL; e_txc = 4'hF;
    end else begin
      int k;
      bit h;
      k = kind_of(rx_data, rx_ctrl);
      if (m_st == 2'd0)      begin e_txd = mac_txd; e_txc = mac_txc; end
      else if (m_st == 2'd1) begin e_txd = RF;      e_txc = 4'b0001; end
      else                   begin e_txd = IDL;     e_txc = 4'hF;    end
      h = 0;
      if (m_cnt > 0 && (m_cyc - m_first) >= 128) m_cnt = 0;
      if (k != 0) begin
        if (m_cnt > 0 && k == m_type) m_cnt++;
        else begin m_cnt = 1; m_type = k; m_first = m_cyc; end
        if (m_cnt == 4) begin h = 1; m_cnt = 0; end
      end
      m_run = (k != 0) ? 0 : m_run + 1;
      if (h) m_st = 2'(m_type);
      else if (m_run >= 128) m_st = 2'd0;
      m_cyc++;
    end
  end

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the reference
  always @(negedge clk) begin
    if (cmp_en) begin
      check("R3 status vs model", 64'(link_status), 64'(m_st));
      check("R5 tx column vs model", {28'h0, xgmii_txc, xgmii_txd}, {28'h0, e_txc, e_txd});
    end
  end

  task automatic send(logic [31:0] d, logic [3:0] c);
    @(negedge clk);
    last_mac_d = mac_txd;
    last_mac_c = mac_txc;
    rx_data = d;
    rx_ctrl = c;
    mac_txd = $urandom;
    mac_txc = 4'($urandom);
  endtask

  task automatic quiet(int n);
    for (int i = 0; i < n; i++) send(IDL, 4'hF);
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 reset status", 64'(link_status), 64'd0);
    check("R1 reset tx", {28'h0, xgmii_txc, xgmii_txd}, {28'h0, 4'hF, IDL});
    cmp_en = 1;

    quiet(5);
    check("R2 pass-through", {28'h0, xgmii_txc, xgmii_txd}, {28'h0, last_mac_c, last_mac_d});

    // R4: fourth message at offset 150 misses the window
    send(LF, 4'b0001); quiet(49); send(LF, 4'b0001); quiet(49);
    send(LF, 4'b0001); quiet(49); send(LF, 4'b0001); quiet(1);
    check("R4 late fourth ignored", 64'(link_status), 64'd0);
    quiet(140);
    // R4: offset 128 misses
    send(LF, 4'b0001); quiet(41); send(LF, 4'b0001); quiet(41);
    send(LF, 4'b0001); quiet(43); send(LF, 4'b0001); quiet(1);
    check("R4 offset 128 misses", 64'(link_status), 64'd0);
    quiet(140);
    // R3: offsets 0,40,80,120
    send(LF, 4'b0001); quiet(39); send(LF, 4'b0001); quiet(39);
    send(LF, 4'b0001); quiet(39);
    check("R3 no fault after three", 64'(link_status), 64'd0);
    send(LF, 4'b0001); quiet(1);
    check("R3 local fault set", 64'(link_status), 64'd1);
    quiet(1);
    check("R5 remote fault column sent", {28'h0, xgmii_txc, xgmii_txd}, {28'h0, 4'b0001, RF});
    quiet(20);
    check("R5 MAC ignored", {28'h0, xgmii_txc, xgmii_txd}, {28'h0, 4'b0001, RF});
    // R6: quiet run restarted by a message, then 127 vs 128
    send(LF, 4'b0001);
    quiet(128);
    check("R6 held after 127 quiet", 64'(link_status), 64'd1);
    quiet(1);
    check("R6 cleared after 128 quiet", 64'(link_status), 64'd0);
    quiet(5);
    // R4: offsets 0,42,84,127 counted
    send(LF, 4'b0001); quiet(41); send(LF, 4'b0001); quiet(41);
    send(LF, 4'b0001); quiet(42); send(LF, 4'b0001); quiet(1);
    check("R4 offset 127 counts", 64'(link_status), 64'd1);
    quiet(135);
    // R7
    send(RF, 4'b0001); send(RF, 4'b0001); send(RF, 4'b0001); send(RF, 4'b0001);
    quiet(1);
    check("R7 remote fault set", 64'(link_status), 64'd2);
    quiet(1);
    check("R7 idle sent", {28'h0, xgmii_txc, xgmii_txd}, {28'h0, 4'hF, IDL});
    quiet(135);
    // R8
    send(LF, 4'b0001); send(LF, 4'b0001); send(LF, 4'b0001); send(RF, 4'b0001);
    quiet(1);
    check("R8 type change restarts", 64'(link_status), 64'd0);
    send(RF, 4'b0001); send(RF, 4'b0001); send(RF, 4'b0001); quiet(1);
    check("R8 new run completes", 64'(link_status), 64'd2);
    // R9 and R11: traffic between local messages, while remote fault held
    send(LF, 4'b0001); send(32'hDEADBEEF, 4'h0); send(LF, 4'b0001); quiet(3);
    send(LF, 4'b0001); send(32'h070707FD, 4'b1111); send(LF, 4'b0001); quiet(1);
    check("R9 traffic keeps count", 64'(link_status), 64'd1);
    check("R11 direct switch", 64'(link_status), 64'd1);
    quiet(135);
    // R10: near misses are not messages and do not break a run
    send(32'h0100009C, 4'b0011); send(32'h0300009C, 4'b0001);
    send(32'h0101009C, 4'b0001); send(32'h0100005C, 4'b0001); quiet(1);
    check("R10 near misses ignored", 64'(link_status), 64'd0);
    send(LF, 4'b0001); send(LF, 4'b0001); send(LF, 4'b0001);
    send(32'h0200009C, 4'b1001); send(LF, 4'b0001); quiet(1);
    check("R10 near miss keeps run", 64'(link_status), 64'd1);
    quiet(3);
    done = 1;
    report();
  end

endmodule